// File: doc/BRIEF.md
# Fast Relock Sequencer for a Ring Oscillator

This block decides when a digitally controlled ring oscillator has lost lock and runs a short, fixed relock sequence. It runs in the system clock domain. It receives a one-clock pulse, `ref_tick`, for every rising edge of the reference clock. On each tick it looks at two inputs:
- the measured phase error, in delay-cell units, which it compares against a configurable threshold;
- the multiplication factor, which it compares against the value it saw at the previous tick.

When either check fails, the sequencer stops the output oscillator on that reference edge and raises the phase-synchronisation indication. It then accepts one freshly estimated control code from the frequency estimator. On the next reference edge it restarts the oscillator, so the restart is phase-aligned to the reference and relock takes two reference cycles. One reference cycle later it hands control back to the closed phase/frequency-detector loop, which does the fine tracking.

The controller has four one-hot states:
- **TRACK**: the closed loop is released and lock is not yet confirmed. This is the reset state.
- **LOCKED**: the closed loop is released and lock is confirmed.
- **SUSPEND**: the oscillator is halted and the sequencer is waiting for a code.
- **RESUME**: the oscillator is running on the new code and the loop is still held.

The transitions are:
- TRACK→LOCKED on a clean tick.
- TRACK→SUSPEND or LOCKED→SUSPEND on a faulty tick.
- SUSPEND→SUSPEND on a tick with no code captured yet.
- SUSPEND→RESUME on a tick after a code was captured.
- RESUME→TRACK on the next tick.

Top module: `fast_relock_seq`

## Requirements
- R1: Synchronous reset (active-low `rst_n`) puts the block in TRACK, which drives these outputs: `osc_en`=1, `phase_sync`=0, `unlock`=1, `loop_release`=1, `code_load`=0 and `code_out`=0.
- R2: At a tick in TRACK or LOCKED where `phase_err` is greater than `thr_m`, the block enters SUSPEND. SUSPEND drives `osc_en`=0, `phase_sync`=1, `unlock`=1 and `loop_release`=0. An error equal to the threshold is not a fault, and the error is examined only on ticks.
- R3: At a tick in TRACK or LOCKED, a `mult_n` that differs from the value captured at the previous tick forces SUSPEND even when the phase error is small. The first tick after reset has no previous value and never counts as a change.
- R4: A tick in TRACK with no fault moves the block to LOCKED. LOCKED drives `unlock`=0 with `osc_en`=1 and `loop_release`=1. A tick in LOCKED with no fault keeps LOCKED.
- R5: The first `code_valid` seen while in SUSPEND is captured. In the next cycle `code_out` holds `code_in` and `code_load` pulses for exactly one cycle. Further strobes in the same suspension, and any strobe outside SUSPEND, leave `code_out` unchanged and give no pulse.
- R6: A tick in SUSPEND, when a code was captured in an earlier cycle of that suspension, moves the block to RESUME. RESUME drives `osc_en`=1, `phase_sync`=0, `unlock`=1 and `loop_release`=0.
- R7: A tick in SUSPEND with no code yet captured keeps SUSPEND for another reference cycle. This includes a strobe that arrives in the same cycle as the tick.
- R8: The next tick in RESUME moves the block to TRACK, which re-asserts `loop_release`. Fault detection is ignored in SUSPEND and RESUME.
- R9: Exactly one state bit is set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference rising edge |
| phase_err | input | ERR_W | Measured phase error magnitude in delay units |
| thr_m | input | ERR_W | Unlock threshold in delay units |
| mult_n | input | N_W | Multiplication factor setting |
| code_in | input | CODE_W | Control code computed by the frequency estimator |
| code_valid | input | 1 | Strobe marking `code_in` as valid |
| osc_en | output | 1 | Enable of the output oscillator |
| phase_sync | output | 1 | High while the oscillator is halted for resynchronisation |
| code_load | output | 1 | One-cycle pulse when `code_out` takes a new code |
| code_out | output | CODE_W | Control code applied to the oscillator |
| unlock | output | 1 | High whenever the block is not in LOCKED |
| loop_release | output | 1 | High when the closed loop owns the oscillator |

## Verification
The assertions take for granted that `ref_tick` is a single-cycle pulse and that `code_in` is stable in the cycle `code_valid` is high. They also assume that `phase_err` and `mult_n` are meaningful only at ticks.

The stimulus is built from these assumptions:
- every reference event is a one-cycle tick separated by idle cycles, or by back-to-back ticks;
- values change only at driven steps;
- the corner cases are approached deliberately: error equal to the threshold, a strobe coinciding with a tick, a second strobe, a strobe outside suspension, a factor change, and faults during the sequence.

// File: rtl/fls_pkg.sv
package fls_pkg;
    typedef enum logic [3:0] {
        FL_TRACK   = 4'b0001,
        FL_LOCKED  = 4'b0010,
        FL_SUSPEND = 4'b0100,
        FL_RESUME  = 4'b1000
    } fl_state_e;
endpackage

// File: rtl/fl_fault_det.sv
module fl_fault_det #(
    parameter int ERR_W = 8,
    parameter int N_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [ERR_W-1:0] phase_err,
    input  logic [ERR_W-1:0] thr_m,
    input  logic [N_W-1:0]   mult_n,
    output logic             fault
);
    logic [N_W-1:0] n_prev;
    logic           n_seen;
    logic           err_over;
    logic           n_moved;

    // factor captured at every reference edge, whatever the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_prev <= '0;
            n_seen <= 1'b0;
        end else if (ref_tick) begin
            n_prev <= mult_n;
            n_seen <= 1'b1;
        end
    end

    always_comb begin
        err_over = phase_err > thr_m;
        n_moved  = n_seen && (mult_n != n_prev);
        fault    = ref_tick && (err_over || n_moved);
    end

    // R3: no factor comparison before the first tick has been seen
    a_r3_first_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!n_seen && ref_tick && !err_over) |-> !fault);
endmodule

// File: rtl/fl_code_hold.sv
module fl_code_hold #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_susp,
    input  logic              arm,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_out,
    output logic              code_load,
    output logic              have_code
);
    logic accept;

    always_comb accept = in_susp && code_valid && !have_code;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out  <= '0;
            code_load <= 1'b0;
            have_code <= 1'b0;
        end else begin
            code_load <= accept;
            if (accept) code_out <= code_in;
            if (arm)         have_code <= 1'b0;
            else if (accept) have_code <= 1'b1;
        end
    end

    // R5: the applied code moves only together with a load pulse
    a_r5_code_moves_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_out) |-> code_load);
    // R5: at most one capture per suspension
    a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        code_load |=> !code_load);
endmodule

// File: rtl/fast_relock_seq.sv
module fast_relock_seq
    import fls_pkg::*;
#(
    parameter int ERR_W  = 8,
    parameter int N_W    = 8,
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ERR_W-1:0]  phase_err,
    input  logic [ERR_W-1:0]  thr_m,
    input  logic [N_W-1:0]    mult_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_valid,
    output logic              osc_en,
    output logic              phase_sync,
    output logic              code_load,
    output logic [CODE_W-1:0] code_out,
    output logic              unlock,
    output logic              loop_release
);
    fl_state_e state, state_nx;
    logic      fault;
    logic      have_code;
    logic      in_susp;
    logic      arm;

    fl_fault_det #(.ERR_W(ERR_W), .N_W(N_W)) u_det (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .phase_err(phase_err), .thr_m(thr_m), .mult_n(mult_n),
        .fault(fault)
    );

    always_comb begin
        in_susp = (state == FL_SUSPEND);
        arm     = !in_susp && (state_nx == FL_SUSPEND);
    end

    fl_code_hold #(.CODE_W(CODE_W)) u_code (
        .clk(clk), .rst_n(rst_n), .in_susp(in_susp), .arm(arm),
        .code_valid(code_valid), .code_in(code_in),
        .code_out(code_out), .code_load(code_load), .have_code(have_code)
    );

    // next-state logic: every move happens on a reference tick
    always_comb begin
        state_nx = state;
        unique case (state)
            FL_TRACK:   if (fault) state_nx = FL_SUSPEND;
                        else if (ref_tick) state_nx = FL_LOCKED;
            FL_LOCKED:  if (fault) state_nx = FL_SUSPEND;
            FL_SUSPEND: if (ref_tick && have_code) state_nx = FL_RESUME;
            FL_RESUME:  if (ref_tick) state_nx = FL_TRACK;
            default:    state_nx = FL_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FL_TRACK;
        else        state <= state_nx;
    end

    // outputs decoded from the state register only
    always_comb begin
        osc_en       = 1'b1;
        phase_sync   = 1'b0;
        unlock       = 1'b1;
        loop_release = 1'b0;
        unique case (state)
            FL_TRACK:   loop_release = 1'b1;
            FL_LOCKED:  begin unlock = 1'b0; loop_release = 1'b1; end
            FL_SUSPEND: begin osc_en = 1'b0; phase_sync = 1'b1; end
            FL_RESUME:  ;
            default:    ;
        endcase
    end

    a_r9_onehot_state: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1);
    a_r2_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && (state == FL_TRACK || state == FL_LOCKED)) |=> (!osc_en && phase_sync));
    a_r6_restart_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> ($past(ref_tick) && $past(have_code)));
    a_r5_load_while_halted: assert property (@(posedge clk) disable iff (!rst_n)
        code_load |-> !osc_en);
    a_r8_release_after_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FL_RESUME && ref_tick) |=> (loop_release && osc_en && unlock));
    a_r4_locked_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |-> (loop_release && osc_en));
endmodule

// File: tb/test_fast_relock_seq.sv
module test_fast_relock_seq;
    typedef enum int {PH_TRACK, PH_LOCKED, PH_SUSP, PH_RES} phase_e;
    typedef struct {
        logic       en, ps, un, rel, ld;
        logic [9:0] code;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [7:0] phase_err = '0, thr_m = 8'd10, mult_n = 8'd50;
    logic [9:0] code_in = '0;
    logic       code_valid = 1'b0;
    logic       osc_en, phase_sync, code_load, unlock, loop_release;
    logic [9:0] code_out;

    int vectors = 0, miscompares = 0, cycles = 0;
    bit done = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    fast_relock_seq i_fast_relock_seq (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .phase_err(phase_err),
        .thr_m(thr_m), .mult_n(mult_n), .code_in(code_in), .code_valid(code_valid),
        .osc_en(osc_en), .phase_sync(phase_sync), .code_load(code_load),
        .code_out(code_out), .unlock(unlock), .loop_release(loop_release)
    );

    task automatic step(input logic tk, input logic [7:0] err, input logic [7:0] n,
                        input logic vl, input logic [9:0] cd, input phase_e ph,
                        input logic ld, input logic [9:0] ec, input string rq);
        exp_t e;
        @(negedge clk);
        ref_tick = tk; phase_err = err; mult_n = n; code_valid = vl; code_in = cd;
        e.en  = (ph != PH_SUSP);
        e.ps  = (ph == PH_SUSP);
        e.un  = (ph != PH_LOCKED);
        e.rel = (ph == PH_TRACK) || (ph == PH_LOCKED);
        e.ld  = ld; e.code = ec; e.req = rq;
        q.push_back(e);
    endtask

    // monitor: one expected item per clock after each driven step
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                vectors++;
                if ({osc_en, phase_sync, unlock, loop_release, code_load} !== {e.en, e.ps, e.un, e.rel, e.ld}
                    || code_out !== e.code) begin
                    miscompares++;
                    $display("FAIL %s: got en=%b ps=%b un=%b rel=%b ld=%b code=%0d, expected en=%b ps=%b un=%b rel=%b ld=%b code=%0d",
                             e.req, osc_en, phase_sync, unlock, loop_release, code_load, code_out,
                             e.en, e.ps, e.un, e.rel, e.ld, e.code);
                end
            end
        end
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                miscompares++;
                $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state; R5 strobe outside SUSPEND ignored
        step(0, 0, 50, 0, 0,   PH_TRACK,  0, 0,   "R1");
        step(0, 0, 50, 1, 77,  PH_TRACK,  0, 0,   "R5");
        // R4 first tick; R3 no factor comparison before it
        step(1, 3, 50, 0, 0,   PH_LOCKED, 0, 0,   "R4");
        step(0, 30, 50, 0, 0,  PH_LOCKED, 0, 0,   "R2");
        step(1, 10, 50, 0, 0,  PH_LOCKED, 0, 0,   "R2");
        step(1, 11, 50, 0, 0,  PH_SUSP,   0, 0,   "R2");
        step(0, 0, 50, 1, 300, PH_SUSP,   1, 300, "R5");
        step(0, 0, 50, 1, 400, PH_SUSP,   0, 300, "R5");
        step(1, 50, 50, 0, 0,  PH_RES,    0, 300, "R6");
        step(1, 50, 60, 0, 0,  PH_TRACK,  0, 300, "R8");
        step(1, 0, 60, 0, 0,   PH_LOCKED, 0, 300, "R4");
        step(1, 0, 61, 0, 0,   PH_SUSP,   0, 300, "R3");
        step(1, 0, 61, 0, 0,   PH_SUSP,   0, 300, "R7");
        step(0, 0, 61, 1, 5,   PH_SUSP,   1, 5,   "R5");
        step(1, 0, 61, 0, 0,   PH_RES,    0, 5,   "R6");
        step(1, 0, 61, 0, 0,   PH_TRACK,  0, 5,   "R8");
        step(1, 40, 61, 0, 0,  PH_SUSP,   0, 5,   "R2");
        step(1, 0, 61, 1, 9,   PH_SUSP,   1, 9,   "R7");
        step(1, 0, 61, 0, 0,   PH_RES,    0, 9,   "R6");
        step(0, 90, 70, 0, 0,  PH_RES,    0, 9,   "R8");
        step(1, 0, 61, 0, 0,   PH_TRACK,  0, 9,   "R8");
        step(1, 0, 61, 0, 0,   PH_LOCKED, 0, 9,   "R4");
        thr_m = 8'd60;
        step(1, 50, 61, 0, 0,  PH_LOCKED, 0, 9,   "R2");
        step(0, 0, 61, 1, 11,  PH_LOCKED, 0, 9,   "R5");
        step(0, 0, 61, 0, 0,   PH_LOCKED, 0, 9,   "R5");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule